// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block decides which operand of a fused multiply-add `(a*b)+c` supplies the NaN result when at least one operand is a NaN. It also decides whether the invalid-operation exception is raised. Upstream logic has already classified each operand and supplies the results as quiet and signaling flags. It also supplies a flag that is set when the product is infinity times zero. Quieting the chosen operand and building the final value are done elsewhere.

A 2-bit policy input selects one of four precedence schemes at run time. A polarity input tells the block whether the signaling bit convention is inverted. One policy uses that input to reorder its operands. The choice code and the invalid flag are captured in registers when a request is accepted. They are presented together with a valid strobe one cycle later.

Top module: `fma_nan_pick`

## Requirements
- R1: After reset, `out_valid`, `choice` and `invalid` are all 0. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. In every other cycle it is 0.
- R2: With `policy` = 0, when `inf_zero` = 1 and `c_qnan` = 1, the result is `choice` = 3 (default NaN) with `invalid` = 1.
- R3: With `policy` = 0, outside the R2 case, the first true condition in this list decides the result: C signaling → 2, A signaling → 0, B signaling → 1, C quiet → 2, A quiet → 0. If none is true, the result is 1. `invalid` = 0.
- R4: With `policy` = 1, when `inf_zero` = 1, the result is `choice` = 3 with `invalid` = 1, whatever the operand flags are.
- R5: With `policy` = 1, `snan_inv` = 1 and `inf_zero` = 0, the first true condition in this list decides the result: A signaling → 0, B signaling → 1, C signaling → 2, A quiet → 0, B quiet → 1. If none is true, the result is 2.
- R6: With `policy` = 1, `snan_inv` = 0 and `inf_zero` = 0, the order is the one given in R3, and the result is 1 if none of its conditions is true.
- R7: With `policy` = 2, when `inf_zero` = 1, the result is `choice` = 2 with `invalid` = 1.
- R8: With `policy` = 2 and `inf_zero` = 0, the result is 0 if A is any NaN (quiet or signaling), else 2 if C is any NaN, else 1.
- R9: With `policy` = 3, the result is 0 if A is any NaN, else 1 if B is any NaN, else 2. `invalid` is always 0, and `inf_zero` has no effect.
- R10: `invalid` is 1 only in the cases named in R2, R4 and R7. Outside those cases it is 0, and `choice` = 3 never appears without `invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| policy | input | 2 | Precedence scheme select (0..3) |
| snan_inv | input | 1 | 1 = inverted signaling-bit convention |
| a_qnan | input | 1 | Operand A is a quiet NaN |
| a_snan | input | 1 | Operand A is a signaling NaN |
| b_qnan | input | 1 | Operand B is a quiet NaN |
| b_snan | input | 1 | Operand B is a signaling NaN |
| c_qnan | input | 1 | Operand C is a quiet NaN |
| c_snan | input | 1 | Operand C is a signaling NaN |
| inf_zero | input | 1 | Product is infinity times zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| choice | output | 2 | 0 = A, 1 = B, 2 = C, 3 = default NaN |
| invalid | output | 1 | Raise invalid-operation |

## Verification
The assertions assume that `policy`, `inf_zero` and the flags are stable during the accepting edge whenever `in_valid` is 1. They also assume that `out_valid` is read one cycle after the request. They do not assume that the classification flags are mutually exclusive. The stimulus therefore sweeps every combination of the six flags, `inf_zero`, polarity and policy, including impossible ones such as an operand flagged both quiet and signaling. It inserts idle gaps so that the strobe timing is exercised as well as back-to-back requests.

// File: rtl/fma_nan_pick.sv
module fma_nan_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] policy,
  input  logic       snan_inv,
  input  logic       a_qnan,
  input  logic       a_snan,
  input  logic       b_qnan,
  input  logic       b_snan,
  input  logic       c_qnan,
  input  logic       c_snan,
  input  logic       inf_zero,
  output logic       out_valid,
  output logic [1:0] choice,
  output logic       invalid
);

  localparam logic [1:0] PICK_A   = 2'd0;
  localparam logic [1:0] PICK_B   = 2'd1;
  localparam logic [1:0] PICK_C   = 2'd2;
  localparam logic [1:0] PICK_DEF = 2'd3;

  logic a_any, b_any, c_any;
  assign a_any = a_qnan | a_snan;
  assign b_any = b_qnan | b_snan;
  assign c_any = c_qnan | c_snan;

  logic [1:0] order_cab;
  logic [1:0] order_abc;
  logic [1:0] sel_nxt;
  logic       raise_nxt;

  always_comb begin
    if      (c_snan) order_cab = PICK_C;
    else if (a_snan) order_cab = PICK_A;
    else if (b_snan) order_cab = PICK_B;
    else if (c_qnan) order_cab = PICK_C;
    else if (a_qnan) order_cab = PICK_A;
    else             order_cab = PICK_B;
  end

  always_comb begin
    if      (a_snan) order_abc = PICK_A;
    else if (b_snan) order_abc = PICK_B;
    else if (c_snan) order_abc = PICK_C;
    else if (a_qnan) order_abc = PICK_A;
    else if (b_qnan) order_abc = PICK_B;
    else             order_abc = PICK_C;
  end

  always_comb begin
    sel_nxt   = PICK_A;
    raise_nxt = 1'b0;
    unique case (policy)
      2'd0: begin
        if (inf_zero && c_qnan) begin
          sel_nxt   = PICK_DEF;
          raise_nxt = 1'b1;
        end else begin
          sel_nxt = order_cab;
        end
      end
      2'd1: begin
        if (inf_zero) begin
          sel_nxt   = PICK_DEF;
          raise_nxt = 1'b1;
        end else if (snan_inv) begin
          sel_nxt = order_abc;
        end else begin
          sel_nxt = order_cab;
        end
      end
      2'd2: begin
        if (inf_zero) begin
          sel_nxt   = PICK_C;
          raise_nxt = 1'b1;
        end else if (a_any) sel_nxt = PICK_A;
        else if (c_any)     sel_nxt = PICK_C;
        else                sel_nxt = PICK_B;
      end
      default: begin
        if (a_any)      sel_nxt = PICK_A;
        else if (b_any) sel_nxt = PICK_B;
        else            sel_nxt = PICK_C;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      choice    <= PICK_A;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        choice  <= sel_nxt;
        invalid <= raise_nxt;
      end
    end
  end

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_p0_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && policy == 2'd0 && inf_zero && c_qnan) |=> (choice == PICK_DEF && invalid));

  assert_p1_infzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && policy == 2'd1 && inf_zero) |=> (choice == PICK_DEF && invalid));

  assert_p2_infzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && policy == 2'd2 && inf_zero) |=> (choice == PICK_C && invalid));

  assert_p3_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && policy == 2'd3) |=> (!invalid && choice != PICK_DEF));

  assert_raise_needs_infzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !inf_zero) |=> !invalid);

  assert_default_implies_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && choice == PICK_DEF) |-> invalid);

endmodule

// File: tb/fma_nan_pick_bench.sv
`timescale 1ns/1ps
module fma_nan_pick_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       snan_inv = 1'b0;
  logic       a_qnan = 1'b0, a_snan = 1'b0;
  logic       b_qnan = 1'b0, b_snan = 1'b0;
  logic       c_qnan = 1'b0, c_snan = 1'b0;
  logic       inf_zero = 1'b0;
  logic       out_valid;
  logic [1:0] choice;
  logic       invalid;

  always #2.5 clk = ~clk;

  fma_nan_pick u_fma_nan_pick (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .policy(policy),
    .snan_inv(snan_inv), .a_qnan(a_qnan), .a_snan(a_snan),
    .b_qnan(b_qnan), .b_snan(b_snan), .c_qnan(c_qnan), .c_snan(c_snan),
    .inf_zero(inf_zero), .out_valid(out_valid), .choice(choice), .invalid(invalid)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] q_choice[$];
  logic       q_inv[$];
  string      q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] pol, input logic inv, input logic [6:0] f,
                       output logic [1:0] ch, output logic rz, output string tag);
    logic aq, as_, bq, bs, cq, cs, iz;
    {aq, as_, bq, bs, cq, cs, iz} = f;
    rz = 1'b0;
    case (pol)
      2'd0: if (iz && cq) begin ch = 3; rz = 1; tag = "R2"; end
            else begin
              tag = "R3";
              ch = cs ? 2 : as_ ? 0 : bs ? 1 : cq ? 2 : aq ? 0 : 1;
            end
      2'd1: if (iz) begin ch = 3; rz = 1; tag = "R4"; end
            else if (inv) begin
              tag = "R5";
              ch = as_ ? 0 : bs ? 1 : cs ? 2 : aq ? 0 : bq ? 1 : 2;
            end else begin
              tag = "R6";
              ch = cs ? 2 : as_ ? 0 : bs ? 1 : cq ? 2 : aq ? 0 : 1;
            end
      2'd2: if (iz) begin ch = 2; rz = 1; tag = "R7"; end
            else begin
              tag = "R8";
              ch = (aq | as_) ? 0 : (cq | cs) ? 2 : 1;
            end
      default: begin
        tag = "R9";
        ch = (aq | as_) ? 0 : (bq | bs) ? 1 : 2;
      end
    endcase
  endtask

  task automatic drive(input logic [1:0] pol, input logic inv, input logic [6:0] f);
    logic [1:0] ch; logic rz; string tag;
    @(negedge clk);
    policy = pol; snan_inv = inv;
    {a_qnan, a_snan, b_qnan, b_snan, c_qnan, c_snan, inf_zero} = f;
    in_valid = 1'b1;
    model(pol, inv, f, ch, rz, tag);
    q_choice.push_back(ch); q_inv.push_back(rz); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    {a_qnan, a_snan, b_qnan, b_snan, c_qnan, c_snan, inf_zero} = 7'h7f;
  endtask

  // monitor: compare against scoreboard queue; idle cycles must show no strobe (R1)
  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_choice.size() == 0) begin
          check(1'b0, "R1", "spurious out_valid", 1, 0);
        end else begin
          logic [1:0] ec; logic ei; string et;
          ec = q_choice.pop_front(); ei = q_inv.pop_front(); et = q_tag.pop_front();
          check(choice == ec, et, "choice", choice, ec);
          check(invalid == ei, ei ? et : "R10", "invalid", invalid, ei);
        end
      end else if (prev_req) begin
        check(1'b0, "R1", "missing out_valid", 0, 1);
      end
    end
    prev_req = in_valid && rst_n;
  end

  initial begin
    #1000000;
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(choice == 2'd0, "R1", "reset choice", choice, 0);
    check(invalid == 1'b0, "R1", "reset invalid", invalid, 0);
    rst_n = 1'b1;
    idle();
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 2; v++) begin
        for (int f = 0; f < 128; f++) begin
          drive(p[1:0], v[0], f[6:0]);
          if (f % 7 == 3) idle();
        end
      end
    end
    idle();
    repeat (4) @(negedge clk);
    check(q_choice.size() == 0, "R1", "pending results", q_choice.size(), 0);
    check(out_valid == 1'b0, "R1", "idle out_valid", out_valid, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule